// File: doc/BRIEF.md
# Binary Morphology Unit

The unit turns a stream of grey-scale pixels into a binary image and keeps it in a small internal frame store of IMG_W × IMG_H pixels, 16 × 16 by default. A second stream can load a reference image into a separate store. After the images are loaded, one write to the configuration word picks an operation and starts it. The unit evaluates a 5 × 5 structuring-element window over the stored image at one pixel per clock. Compound operations chain several such passes, and their intermediate images alternate between two internal work buffers.

The result of the final pass streams out in raster order, one pixel per clock with a valid strobe. A one-cycle done pulse follows it. The operations are erosion, dilation, opening, closing, a four-pass noise filter, hit-or-miss with a second structuring element, differencing against the reference image, and a plain read-out of the thresholded image. The main structuring element defaults to a cross: the centre row and the centre column are set. The auxiliary element defaults to the four diagonal neighbours at distance one.

Top module: `morph_unit`

## Requirements
- R1: A loaded grey pixel is stored as 1 when its value is greater than or equal to the threshold currently held in bits [7:0] of the configuration word, and as 0 otherwise.
- R2: Erosion (opcode 0) outputs 1 at a pixel only if every set position of the main element lands on a 1 in the image. Positions outside the frame read as 0, so an all-ones frame eroded by the cross loses its two outermost rings.
- R3: Dilation (opcode 1) outputs 1 at a pixel if any set position of the main element, mirrored through the centre, lands on a 1 in the image.
- R4: Opening (opcode 2) is an erosion pass followed by a dilation pass. Closing (opcode 3) is a dilation pass followed by an erosion pass. Both passes use the main element.
- R5: Noise filtering (opcode 4) runs four passes in this order: erode, dilate, dilate, erode.
- R6: Hit-or-miss (opcode 5) outputs the AND of two results: the image eroded by the main element, and the inverted image eroded by the auxiliary element. Only in-frame pixels are inverted; out-of-frame positions still read as 0.
- R7: Differencing (opcode 6) outputs the XOR of the primary image and the reference image at each pixel.
- R8: Configuration word layout: bits [7:0] hold the threshold, bits [10:8] the opcode, and bit 11 the start bit. Opcode 7 outputs the primary image unchanged.
- R9: Pixel writes go in raster order, with index = row × IMG_W + column. When pix_sel = 0 the pixel goes to the primary store; when pix_sel = 1 it goes to the reference store. Both stores share one write counter, which returns to 0 after IMG_W × IMG_H writes.
- R10: Each pass takes IMG_W × IMG_H cycles. For an operation of P passes, the first output pixel is valid (P−1)·N+1 clock edges after the edge that samples the start write. Exactly N pixels then follow on consecutive cycles.
- R11: done is high for exactly one cycle: the cycle right after the last valid output pixel.
- R12: While an operation runs, configuration writes and pixel writes are ignored. They do not start a run, change the threshold, or modify either image store.
- R13: After reset, out_valid and done are 0, and every image store holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | PIX_W+4 | Threshold, opcode and start bit |
| pix_valid | input | 1 | Grey pixel write strobe |
| pix_sel | input | 1 | 0 selects the primary store, 1 the reference store |
| pix_grey | input | PIX_W | Grey pixel value |
| out_valid | output | 1 | Result pixel strobe |
| out_pix | output | 1 | Result pixel in raster order |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs an all-ones frame through erosion. A design that read out-of-frame neighbours as 1, or as wrapped pixels, would keep the border lit. Pixels sitting exactly at the threshold and one below it catch an off-by-one compare. Hit-or-miss on a noisy image catches two faults: inverting out-of-frame positions, and mixing up the two elements. Pass ordering is shown up in two ways: each compound operator is checked against its own pass sequence, and the first-output latency is measured. A four-pass filter that skipped a pass would be 256 cycles early. Writes injected during a run must change neither the current result nor the stored image seen by a later read-out.

// File: rtl/morph_pkg.sv
package morph_pkg;

    localparam int SE_DIM  = 5;
    localparam int SE_RAD  = SE_DIM / 2;
    localparam int SE_BITS = SE_DIM * SE_DIM;

    function automatic logic [SE_BITS-1:0] se_cross();
        logic [SE_BITS-1:0] v;
        v = '0;
        for (int r = 0; r < SE_DIM; r++)
            for (int c = 0; c < SE_DIM; c++)
                if (r == SE_RAD || c == SE_RAD) v[r*SE_DIM+c] = 1'b1;
        return v;
    endfunction

    function automatic logic [SE_BITS-1:0] se_diag();
        logic [SE_BITS-1:0] v;
        v = '0;
        for (int r = 0; r < SE_DIM; r++)
            for (int c = 0; c < SE_DIM; c++)
                if ((r == SE_RAD-1 || r == SE_RAD+1) && (c == SE_RAD-1 || c == SE_RAD+1))
                    v[r*SE_DIM+c] = 1'b1;
        return v;
    endfunction

    localparam logic [SE_BITS-1:0] SE_CROSS = se_cross();
    localparam logic [SE_BITS-1:0] SE_DIAG  = se_diag();

    typedef enum logic [2:0] {
        OP_ERODE   = 3'd0,
        OP_DILATE  = 3'd1,
        OP_OPEN    = 3'd2,
        OP_CLOSE   = 3'd3,
        OP_DENOISE = 3'd4,
        OP_HITMISS = 3'd5,
        OP_DIFF    = 3'd6,
        OP_PASS    = 3'd7
    } morph_op_e;

    typedef enum logic [2:0] {
        K_ERODE, K_DILATE, K_HITMISS, K_XOR, K_COPY
    } pass_kind_e;

    typedef enum logic [1:0] {
        BUF_IMG, BUF_W0, BUF_W1
    } buf_sel_e;

    typedef struct packed {
        pass_kind_e kind;
        buf_sel_e   src;
        buf_sel_e   dst;
        logic       last;
    } pass_desc_t;

    // Pass schedule: which primitive runs at each step of each opcode
    function automatic pass_desc_t pass_plan(morph_op_e op, logic [1:0] step);
        pass_desc_t d;
        d.kind = K_COPY;
        d.src  = BUF_IMG;
        d.dst  = BUF_W0;
        d.last = 1'b1;
        case (op)
            OP_ERODE:  d.kind = K_ERODE;
            OP_DILATE: d.kind = K_DILATE;
            OP_OPEN: begin
                d.kind = (step == 2'd0) ? K_ERODE : K_DILATE;
                d.src  = (step == 2'd0) ? BUF_IMG : BUF_W0;
                d.last = (step != 2'd0);
            end
            OP_CLOSE: begin
                d.kind = (step == 2'd0) ? K_DILATE : K_ERODE;
                d.src  = (step == 2'd0) ? BUF_IMG : BUF_W0;
                d.last = (step != 2'd0);
            end
            OP_DENOISE: begin
                case (step)
                    2'd0: begin d.kind = K_ERODE;  d.src = BUF_IMG; d.dst = BUF_W0; d.last = 1'b0; end
                    2'd1: begin d.kind = K_DILATE; d.src = BUF_W0;  d.dst = BUF_W1; d.last = 1'b0; end
                    2'd2: begin d.kind = K_DILATE; d.src = BUF_W1;  d.dst = BUF_W0; d.last = 1'b0; end
                    default: begin d.kind = K_ERODE; d.src = BUF_W0; d.dst = BUF_W1; d.last = 1'b1; end
                endcase
            end
            OP_HITMISS: begin
                d.kind = (step == 2'd0) ? K_ERODE : K_HITMISS;
                d.src  = (step == 2'd0) ? BUF_IMG : BUF_W0;
                d.last = (step != 2'd0);
            end
            OP_DIFF:  d.kind = K_XOR;
            default:  d.kind = K_COPY;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/morph_thresh.sv
module morph_thresh #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] grey,
    input  logic [PIX_W-1:0] level,
    output logic             bin
);
    assign bin = (grey >= level);
endmodule

// File: rtl/morph_window.sv
module morph_window
    import morph_pkg::*;
#(
    parameter int IMG_W      = 16,
    parameter int IMG_H      = 16,
    parameter bit REFLECT_OR = 1'b0
) (
    input  logic [IMG_W*IMG_H-1:0]         img,
    input  logic                           invert,
    input  logic [SE_BITS-1:0]             se,
    input  logic [$clog2(IMG_W*IMG_H)-1:0] pix,
    output logic                           hit
);
    localparam int AW = $clog2(IMG_W*IMG_H);

    logic [SE_BITS-1:0] tap;

    for (genvar r = 0; r < SE_DIM; r++) begin : g_row
        for (genvar c = 0; c < SE_DIM; c++) begin : g_col
            localparam int OY = REFLECT_OR ? (SE_RAD - r) : (r - SE_RAD);
            localparam int OX = REFLECT_OR ? (SE_RAD - c) : (c - SE_RAD);
            logic t;
            always_comb begin
                int ty, tx;
                ty = int'(pix) / IMG_W + OY;
                tx = int'(pix) % IMG_W + OX;
                if (ty < 0 || ty >= IMG_H || tx < 0 || tx >= IMG_W)
                    t = 1'b0;
                else
                    t = img[AW'(ty*IMG_W + tx)] ^ invert;
            end
            assign tap[r*SE_DIM+c] = t;
        end
    end

    if (REFLECT_OR) begin : g_any
        assign hit = |(tap & se);
    end else begin : g_all
        assign hit = &(tap | ~se);
    end
endmodule

// File: rtl/morph_ctrl.sv
module morph_ctrl
    import morph_pkg::*;
#(
    parameter int NPIX = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic [2:0]              launch_op,
    output pass_desc_t              desc,
    output logic [$clog2(NPIX)-1:0] pix,
    output logic                    active,
    output logic                    final_pix
);
    localparam int AW = $clog2(NPIX);

    typedef struct packed {
        logic          active;
        morph_op_e     op;
        logic [1:0]    step;
        logic [AW-1:0] pix;
    } ctrl_t;

    ctrl_t s_q, s_d;
    logic  wrap;

    assign desc      = pass_plan(s_q.op, s_q.step);
    assign wrap      = (s_q.pix == AW'(NPIX-1));
    assign pix       = s_q.pix;
    assign active    = s_q.active;
    assign final_pix = s_q.active & desc.last & wrap;

    always_comb begin
        s_d = s_q;
        if (!s_q.active) begin
            if (launch) begin
                s_d.active = 1'b1;
                s_d.op     = morph_op_e'(launch_op);
                s_d.step   = 2'd0;
                s_d.pix    = '0;
            end
        end else if (wrap) begin
            s_d.pix = '0;
            if (desc.last) s_d.active = 1'b0;
            else           s_d.step   = s_q.step + 2'd1;
        end else begin
            s_d.pix = s_q.pix + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_launch_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && launch) |=> (active && pix == '0));

    p_pix_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !wrap) |=> (active && pix == $past(pix) + AW'(1)));

    p_stops_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        final_pix |=> !active);

    p_denoise_four_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && s_q.op == OP_DENOISE && s_q.step != 2'd3) |-> !desc.last);
endmodule

// File: rtl/morph_unit.sv
module morph_unit
    import morph_pkg::*;
#(
    parameter int                  IMG_W   = 16,
    parameter int                  IMG_H   = 16,
    parameter int                  PIX_W   = 8,
    parameter logic [SE_BITS-1:0]  SE_MAIN = SE_CROSS,
    parameter logic [SE_BITS-1:0]  SE_AUX  = SE_DIAG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [PIX_W+3:0] cfg_wdata,
    input  logic             pix_valid,
    input  logic             pix_sel,
    input  logic [PIX_W-1:0] pix_grey,
    output logic             out_valid,
    output logic             out_pix,
    output logic             done
);
    localparam int NPIX      = IMG_W * IMG_H;
    localparam int AW        = $clog2(NPIX);
    localparam int OP_LSB    = PIX_W;
    localparam int START_BIT = PIX_W + 3;

    typedef struct packed {
        logic [NPIX-1:0]  img;
        logic [NPIX-1:0]  refb;
        logic [NPIX-1:0]  w0;
        logic [NPIX-1:0]  w1;
        logic [PIX_W-1:0] thr;
        logic [AW-1:0]    ld_cnt;
        logic             out_valid;
        logic             out_pix;
        logic             fin;
        logic             done;
    } unit_t;

    unit_t s_q, s_d;

    logic            busy, launch, grey_bin, final_pix;
    logic            ero_main, dil_main, ero_aux, res;
    logic [AW-1:0]   pix;
    logic [NPIX-1:0] src_vec;
    pass_desc_t      desc;

    assign launch = cfg_we & cfg_wdata[START_BIT] & ~busy;

    morph_thresh #(.PIX_W(PIX_W)) u_thresh (
        .grey  (pix_grey),
        .level (s_q.thr),
        .bin   (grey_bin)
    );

    morph_ctrl #(.NPIX(NPIX)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_op (cfg_wdata[OP_LSB +: 3]),
        .desc      (desc),
        .pix       (pix),
        .active    (busy),
        .final_pix (final_pix)
    );

    always_comb begin
        case (desc.src)
            BUF_W0:  src_vec = s_q.w0;
            BUF_W1:  src_vec = s_q.w1;
            default: src_vec = s_q.img;
        endcase
    end

    morph_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .REFLECT_OR(1'b0)) u_win_ero (
        .img (src_vec), .invert (1'b0), .se (SE_MAIN), .pix (pix), .hit (ero_main)
    );

    morph_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .REFLECT_OR(1'b1)) u_win_dil (
        .img (src_vec), .invert (1'b0), .se (SE_MAIN), .pix (pix), .hit (dil_main)
    );

    morph_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .REFLECT_OR(1'b0)) u_win_aux (
        .img (s_q.img), .invert (1'b1), .se (SE_AUX), .pix (pix), .hit (ero_aux)
    );

    always_comb begin
        case (desc.kind)
            K_ERODE:   res = ero_main;
            K_DILATE:  res = dil_main;
            K_HITMISS: res = src_vec[pix] & ero_aux;
            K_XOR:     res = s_q.img[pix] ^ s_q.refb[pix];
            default:   res = s_q.img[pix];
        endcase
    end

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.fin       = 1'b0;
        s_d.done      = s_q.fin;

        if (cfg_we && !busy) s_d.thr = cfg_wdata[PIX_W-1:0];

        if (pix_valid && !busy) begin
            if (pix_sel) s_d.refb[s_q.ld_cnt] = grey_bin;
            else         s_d.img[s_q.ld_cnt]  = grey_bin;
            s_d.ld_cnt = (s_q.ld_cnt == AW'(NPIX-1)) ? '0 : s_q.ld_cnt + AW'(1);
        end

        if (busy) begin
            if (desc.last) begin
                s_d.out_valid = 1'b1;
                s_d.out_pix   = res;
                s_d.fin       = final_pix;
            end else if (desc.dst == BUF_W1) begin
                s_d.w1[pix] = res;
            end else begin
                s_d.w0[pix] = res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.out_valid;
    assign out_pix   = s_q.out_pix;
    assign done      = s_q.done;

    p_done_after_stream_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && $past(out_valid)));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_stores_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(s_q.img) && $stable(s_q.refb)));

    p_thr_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(s_q.thr));

    p_out_needs_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));
endmodule

// File: tb/morph_unit_bench.sv
`timescale 1ns/1ps
module morph_unit_bench;
    localparam int W = 16;
    localparam int H = 16;
    localparam int N = W * H;
    localparam logic [24:0] SE_X = 25'h0427C84;
    localparam logic [24:0] SE_D = 25'h0050140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic        pix_sel = 1'b0;
    logic [7:0]  pix_grey = '0;
    logic        out_valid, out_pix, done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    morph_unit u_morph_unit (
        .clk, .rst_n, .cfg_we, .cfg_wdata, .pix_valid, .pix_sel, .pix_grey,
        .out_valid, .out_pix, .done
    );

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] pa;
        logic [2:0] pr;
        logic [7:0] thr;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'd0, 3'd2, 3'd0, 8'd100},
        '{3'd0, 3'd3, 3'd0, 8'd255},
        '{3'd1, 3'd1, 3'd0, 8'd128},
        '{3'd1, 3'd2, 3'd0, 8'd100},
        '{3'd2, 3'd2, 3'd0, 8'd100},
        '{3'd3, 3'd2, 3'd0, 8'd100},
        '{3'd4, 3'd1, 3'd0, 8'd128},
        '{3'd4, 3'd2, 3'd0, 8'd100},
        '{3'd5, 3'd2, 3'd0, 8'd100},
        '{3'd5, 3'd1, 3'd0, 8'd128},
        '{3'd6, 3'd1, 3'd2, 8'd128},
        '{3'd7, 3'd1, 3'd0, 8'd90}
    };

    function automatic logic [7:0] grey_of(int pat, int x, int y);
        case (pat)
            1: return 8'((x*37 + y*91 + x*y*13 + 11) % 256);
            2: begin
                if ((x == 1 && y == 14) || (x == 14 && y == 1)) return 8'd200;
                if (x == 7 && y == 7) return 8'd10;
                if (x >= 3 && x <= 11 && y >= 2 && y <= 12) return 8'd180;
                return 8'd30;
            end
            3: return 8'd255;
            4: return ((x + y) % 2 == 1) ? 8'd77 : 8'd76;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [N-1:0] bin_img(int pat, logic [7:0] thr);
        logic [N-1:0] v;
        for (int p = 0; p < N; p++) v[p] = (grey_of(pat, p % W, p / W) >= thr);
        return v;
    endfunction

    function automatic bit rd(logic [N-1:0] im, int y, int x, bit inv);
        if (y < 0 || y >= H || x < 0 || x >= W) return 1'b0;
        return im[y*W+x] ^ inv;
    endfunction

    function automatic logic [N-1:0] m_erode(logic [N-1:0] im, logic [24:0] se, bit inv);
        logic [N-1:0] v;
        for (int p = 0; p < N; p++) begin
            v[p] = 1'b1;
            for (int k = 0; k < 25; k++)
                if (se[k] && !rd(im, p/W + k/5 - 2, p%W + k%5 - 2, inv)) v[p] = 1'b0;
        end
        return v;
    endfunction

    function automatic logic [N-1:0] m_dilate(logic [N-1:0] im, logic [24:0] se);
        logic [N-1:0] v;
        for (int p = 0; p < N; p++) begin
            v[p] = 1'b0;
            for (int k = 0; k < 25; k++)
                if (se[k] && rd(im, p/W - (k/5 - 2), p%W - (k%5 - 2), 1'b0)) v[p] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [N-1:0] model(int op, logic [N-1:0] a, logic [N-1:0] r);
        case (op)
            0: return m_erode(a, SE_X, 1'b0);
            1: return m_dilate(a, SE_X);
            2: return m_dilate(m_erode(a, SE_X, 1'b0), SE_X);
            3: return m_erode(m_dilate(a, SE_X), SE_X, 1'b0);
            4: return m_erode(m_dilate(m_dilate(m_erode(a, SE_X, 1'b0), SE_X), SE_X), SE_X, 1'b0);
            5: return m_erode(a, SE_X, 1'b0) & m_erode(a, SE_D, 1'b1);
            6: return a ^ r;
            default: return a;
        endcase
    endfunction

    function automatic int passes(int op);
        case (op)
            2, 3, 5: return 2;
            4:       return 4;
            default: return 1;
        endcase
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] op, input logic [7:0] thr, input logic start);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {start, op, thr};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic load(input int pat, input logic sel);
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_sel   = sel;
            pix_grey  = grey_of(pat, p % W, p / W);
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic run(input int op, input logic [7:0] thr, input logic [N-1:0] exp,
                       input string req, input bit interfere);
        int           cnt;
        bit           stream_ok;
        logic [N-1:0] got;
        cfg_write(3'(op), thr, 1'b1);
        check(out_valid == 1'b0, "R10", "no output in first run cycle", int'(out_valid), 0);
        cnt = 0;
        while (!out_valid && cnt < 5000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (interfere) begin
                pix_valid = (cnt <= 256);
                pix_grey  = 8'hFF;
                pix_sel   = cnt[0];
                cfg_we    = (cnt == 10);
                cfg_wdata = {1'b1, 3'd7, 8'd0};
            end
        end
        pix_valid = 1'b0;
        cfg_we    = 1'b0;
        check(cnt == (passes(op) - 1) * N + 1, "R10", "first output latency", cnt, (passes(op) - 1) * N + 1);
        stream_ok = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (!out_valid) stream_ok = 1'b0;
            got[i] = out_pix;
            @(negedge clk);
        end
        check(stream_ok, "R10", "consecutive valid pixels", int'(stream_ok), 1);
        check(!out_valid && done, "R11", "done right after last pixel", int'({out_valid, done}), 1);
        @(negedge clk);
        check(!done, "R11", "done lasts one cycle", int'(done), 0);
        check(got == exp, req, "result pixel mismatches", $countones(got ^ exp), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] a, r;

        // R13: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !done, "R13", "outputs low in reset", int'({out_valid, done}), 0);
        rst_n = 1'b1;
        run(7, 8'd0, '0, "R13", 1'b0);

        // table of vectors
        for (int i = 0; i < 12; i++) begin
            cfg_write(VECS[i].op, VECS[i].thr, 1'b0);
            load(int'(VECS[i].pa), 1'b0);
            load(int'(VECS[i].pr), 1'b1);
            a = bin_img(int'(VECS[i].pa), VECS[i].thr);
            r = bin_img(int'(VECS[i].pr), VECS[i].thr);
            run(int'(VECS[i].op), VECS[i].thr, model(int'(VECS[i].op), a, r), req_of(int'(VECS[i].op)), 1'b0);
        end

        // R1: values equal to and one below the threshold
        cfg_write(3'd7, 8'd77, 1'b0);
        load(4, 1'b0);
        run(7, 8'd77, bin_img(4, 8'd77), "R1", 1'b0);

        // R9: a second primary frame wraps the counter and overwrites the first
        cfg_write(3'd7, 8'd128, 1'b0);
        load(1, 1'b0);
        load(2, 1'b0);
        run(7, 8'd128, bin_img(2, 8'd128), "R9", 1'b0);

        // R12: writes during a four-pass run are ignored
        cfg_write(3'd4, 8'd128, 1'b0);
        load(1, 1'b0);
        a = bin_img(1, 8'd128);
        run(4, 8'd128, model(4, a, '0), "R12", 1'b1);
        run(7, 8'd128, a, "R12", 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule